// File: doc/BRIEF.md
# Processor Fault Flag Register

This block keeps a sticky record of fault conditions inside a small 16-bit processor core. The pipeline and the bus interface send one-cycle strobes when an access faults: an odd address, memory that does not exist, an I/O-page device that never answers, or a HALT executed outside kernel mode. Each strobe sets its own flag bit, and the flag stays set until software writes the register. The register is a memory-mapped word, so any write clears it.

The block also checks kernel-mode stack pushes. A push into the warning band just above the bottom of the stack sets a warning flag. It requests a trap only when that flag was clear beforehand, so a handler that has not yet cleared the register is not trapped again. A push through an odd stack pointer, or below the warning band, is a hard stack violation and raises an abort request.

A general reset clears the register, and so does the reset that restarts only the CPU. Because of this, a restarted CPU never inherits flags from an earlier run.

Top module: `errstat_reg`

## Requirements
- R1: A bus write (`bus_we` high) clears every flag to zero on the next clock edge.
- R2: An odd-address fault strobe sets bit 6 (octal 000100).
- R3: A missing-memory fault strobe sets bit 5 (octal 000040).
- R4: An I/O-page timeout strobe sets bit 4 (octal 000020).
- R5: A HALT-outside-kernel strobe sets bit 7 (octal 000200). With bits 5 and 4 already set, the register reads octal 000260.
- R6: Flags are sticky. A new event ORs its bit into the bits already set, and no event clears a bit.
- R7: A kernel push to an even address A with octal 340 <= A < octal 400 sets bit 3 (octal 000010). `yel_trap` pulses for one cycle, one cycle after the push, only if bit 3 was clear before the push. A push at or above octal 400 changes nothing.
- R8: A kernel push to an odd address sets bits 6 and 2 together (octal 000104), and `red_abort` pulses for one cycle, one cycle after the push.
- R9: A kernel push to an even address below octal 340 sets bit 2 (octal 000004) and pulses `red_abort`.
- R10: `greset` or `creset` held high at a clock edge clears the register, `yel_trap` and `red_abort`. Reset takes priority over any event in the same cycle.
- R11: Bits 15..8, bit 1 and bit 0 always read as zero.
- R12: When an event and a bus write arrive in the same cycle, the register holds the event's flag afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| greset | input | 1 | General synchronous reset, active high |
| creset | input | 1 | CPU-only synchronous reset, active high |
| ev_odd_addr | input | 1 | Odd-address fault strobe |
| ev_no_mem | input | 1 | Missing-memory fault strobe |
| ev_io_tmo | input | 1 | I/O-page timeout strobe |
| ev_user_halt | input | 1 | HALT-outside-kernel strobe |
| kpush_valid | input | 1 | Kernel-mode stack push strobe |
| kpush_addr | input | ADDR_W (16) | Address of the kernel push |
| bus_we | input | 1 | Register write strobe (the data is ignored) |
| reg_value | output | DATA_W (16) | Current flag word |
| yel_trap | output | 1 | Warning-band stack trap request, one-cycle pulse |
| red_abort | output | 1 | Hard stack violation abort request, one-cycle pulse |

## Verification
The bench builds the block with its default parameters: 16-bit data and address, a warning band from octal 340 up to octal 400, and a hard-violation limit at octal 340. With these values both band edges lie at small addresses, so pushes at 336, 340, 374, 376 and 400 probe each boundary directly. The same values let the bench exercise the repeated-push suppression, the collision between a write and an event, and the reset priority on a short table of vectors.

// File: rtl/errstat_pkg.sv
package errstat_pkg;
  localparam int FLAG_W  = 8;
  localparam int B_HLT   = 7;
  localparam int B_ODD   = 6;
  localparam int B_NXM   = 5;
  localparam int B_TMO   = 4;
  localparam int B_YEL   = 3;
  localparam int B_RED   = 2;
  localparam logic [FLAG_W-1:0] LIVE_MASK = 8'b1111_1100;
endpackage

// File: rtl/errstat_zone.sv
module errstat_zone #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] YEL_LIMIT = 16'o400,
  parameter logic [ADDR_W-1:0] RED_LIMIT = 16'o340
) (
  input  logic              push_valid,
  input  logic [ADDR_W-1:0] push_addr,
  output logic              hit_odd,
  output logic              hit_low,
  output logic              hit_yellow
);
  logic below_yel, below_red;

  always_comb begin
    below_yel  = push_addr < YEL_LIMIT;
    below_red  = push_addr < RED_LIMIT;
    hit_odd    = push_valid && push_addr[0];
    hit_low    = push_valid && !push_addr[0] && below_red;
    hit_yellow = push_valid && !push_addr[0] && below_yel && !below_red;
  end

  always_comb begin
    assert_zone_exclusive_R7: assert ($onehot0({hit_odd, hit_low, hit_yellow}));
  end
endmodule

// File: rtl/errstat_flags.sv
module errstat_flags
  import errstat_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] set_bits,
  input  logic              yel_hit,
  input  logic              red_hit,
  output logic [DATA_W-1:0] value,
  output logic              yel_trap,
  output logic              red_abort
);
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] base;

  always_comb base = clr_we ? '0 : flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= '0;
      yel_trap  <= 1'b0;
      red_abort <= 1'b0;
    end else begin
      flags     <= (base | set_bits) & LIVE_MASK;
      yel_trap  <= yel_hit && !flags[B_YEL];
      red_abort <= red_hit;
    end
  end

  assign value = {{(DATA_W-FLAG_W){1'b0}}, flags};

  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((value & $past(value)) == $past(value)));
  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    (clr_we && set_bits == '0) |=> (value == '0));
  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (value[DATA_W-1:FLAG_W] == '0) && (value[1:0] == 2'b00));
  assert_trap_flag_R7: assert property (@(posedge clk) disable iff (rst)
    yel_trap |-> value[B_YEL]);
  assert_trap_once_R7: assert property (@(posedge clk) disable iff (rst)
    yel_trap |-> !$past(value[B_YEL]));
  assert_abort_flag_R9: assert property (@(posedge clk) disable iff (rst)
    red_abort |-> value[B_RED]);
  assert_event_wins_R12: assert property (@(posedge clk) disable iff (rst)
    (clr_we && set_bits[B_ODD]) |=> value[B_ODD]);
endmodule

// File: rtl/errstat_reg.sv
module errstat_reg
  import errstat_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] YEL_LIMIT = 16'o400,
  parameter logic [ADDR_W-1:0] RED_LIMIT = 16'o340
) (
  input  logic              clk,
  input  logic              greset,
  input  logic              creset,
  input  logic              ev_odd_addr,
  input  logic              ev_no_mem,
  input  logic              ev_io_tmo,
  input  logic              ev_user_halt,
  input  logic              kpush_valid,
  input  logic [ADDR_W-1:0] kpush_addr,
  input  logic              bus_we,
  output logic [DATA_W-1:0] reg_value,
  output logic              yel_trap,
  output logic              red_abort
);
  logic              rst;
  logic              hit_odd, hit_low, hit_yellow;
  logic [FLAG_W-1:0] set_bits;

  assign rst = greset | creset;

  errstat_zone #(
    .ADDR_W(ADDR_W), .YEL_LIMIT(YEL_LIMIT), .RED_LIMIT(RED_LIMIT)
  ) u_zone (
    .push_valid(kpush_valid),
    .push_addr (kpush_addr),
    .hit_odd   (hit_odd),
    .hit_low   (hit_low),
    .hit_yellow(hit_yellow)
  );

  always_comb begin
    set_bits        = '0;
    set_bits[B_HLT] = ev_user_halt;
    set_bits[B_ODD] = ev_odd_addr | hit_odd;
    set_bits[B_NXM] = ev_no_mem;
    set_bits[B_TMO] = ev_io_tmo;
    set_bits[B_YEL] = hit_yellow;
    set_bits[B_RED] = hit_odd | hit_low;
  end

  errstat_flags #(.DATA_W(DATA_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .clr_we   (bus_we),
    .set_bits (set_bits),
    .yel_hit  (hit_yellow),
    .red_hit  (hit_odd | hit_low),
    .value    (reg_value),
    .yel_trap (yel_trap),
    .red_abort(red_abort)
  );

  assert_odd_push_R8: assert property (@(posedge clk) disable iff (rst)
    (kpush_valid && kpush_addr[0]) |=> (red_abort && reg_value[B_ODD] && reg_value[B_RED]));
  assert_halt_flag_R5: assert property (@(posedge clk) disable iff (rst)
    ev_user_halt |=> reg_value[B_HLT]);
endmodule

// File: tb/sim_errstat_reg.sv
module sim_errstat_reg;
  logic        clk = 1'b0;
  logic        greset = 1'b1, creset = 1'b0;
  logic        ev_odd_addr = 0, ev_no_mem = 0, ev_io_tmo = 0, ev_user_halt = 0;
  logic        kpush_valid = 0;
  logic [15:0] kpush_addr = '0;
  logic        bus_we = 0;
  logic [15:0] reg_value;
  logic        yel_trap, red_abort;
  int checks = 0, errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  errstat_reg u0 (
    .clk(clk), .greset(greset), .creset(creset),
    .ev_odd_addr(ev_odd_addr), .ev_no_mem(ev_no_mem), .ev_io_tmo(ev_io_tmo),
    .ev_user_halt(ev_user_halt), .kpush_valid(kpush_valid), .kpush_addr(kpush_addr),
    .bus_we(bus_we), .reg_value(reg_value), .yel_trap(yel_trap), .red_abort(red_abort)
  );

  // entry: [39:36] {halt,odd,nxm,tmo} [35] push [34:19] addr [18] we
  //        [17:2] expected word [1] expected trap [0] expected abort
  localparam int NV = 15;
  localparam logic [39:0] VEC [NV] = '{
    {4'b0000, 1'b0, 16'o0,    1'b1, 16'o000000, 1'b0, 1'b0}, // R1
    {4'b0100, 1'b0, 16'o0,    1'b0, 16'o000100, 1'b0, 1'b0}, // R2
    {4'b0000, 1'b0, 16'o0,    1'b1, 16'o000000, 1'b0, 1'b0}, // R1
    {4'b0010, 1'b0, 16'o0,    1'b0, 16'o000040, 1'b0, 1'b0}, // R3
    {4'b0001, 1'b0, 16'o0,    1'b0, 16'o000060, 1'b0, 1'b0}, // R4 R6
    {4'b1000, 1'b0, 16'o0,    1'b0, 16'o000260, 1'b0, 1'b0}, // R5
    {4'b0000, 1'b0, 16'o0,    1'b1, 16'o000000, 1'b0, 1'b0}, // R1
    {4'b0000, 1'b1, 16'o376,  1'b0, 16'o000010, 1'b1, 1'b0}, // R7 trap
    {4'b0000, 1'b1, 16'o374,  1'b0, 16'o000010, 1'b0, 1'b0}, // R7 suppressed
    {4'b0000, 1'b0, 16'o0,    1'b1, 16'o000000, 1'b0, 1'b0}, // R1
    {4'b0000, 1'b1, 16'o1001, 1'b0, 16'o000104, 1'b0, 1'b1}, // R8
    {4'b0000, 1'b1, 16'o336,  1'b1, 16'o000004, 1'b0, 1'b1}, // R9 R12
    {4'b0000, 1'b1, 16'o400,  1'b0, 16'o000004, 1'b0, 1'b0}, // R7 above band
    {4'b0000, 1'b1, 16'o340,  1'b0, 16'o000014, 1'b1, 1'b0}, // R7 lower edge
    {4'b0000, 1'b0, 16'o0,    1'b0, 16'o000014, 1'b0, 1'b0}  // R7 R8 pulse ends
  };

  task automatic check(input string tag, input logic [15:0] ev, input logic et, input logic ea);
    checks++;
    if (reg_value !== ev || yel_trap !== et || red_abort !== ea) begin
      errors++;
      $display("FAIL %s: got word %o trap %b abort %b, expected word %o trap %b abort %b",
               tag, reg_value, yel_trap, red_abort, ev, et, ea);
    end
  endtask

  task automatic clear_inputs();
    {ev_user_halt, ev_odd_addr, ev_no_mem, ev_io_tmo} = 4'b0;
    kpush_valid = 0; kpush_addr = '0; bus_we = 0;
  endtask

  initial begin
    while (cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset state", 16'o0, 1'b0, 1'b0);
    greset = 0;

    for (int i = 0; i < NV; i++) begin
      {ev_user_halt, ev_odd_addr, ev_no_mem, ev_io_tmo} = VEC[i][39:36];
      kpush_valid = VEC[i][35];
      kpush_addr  = VEC[i][34:19];
      bus_we      = VEC[i][18];
      @(posedge clk); @(negedge clk);
      check($sformatf("vector %0d", i), VEC[i][17:2], VEC[i][1], VEC[i][0]);
      clear_inputs();
    end

    // R10: CPU-only reset clears accumulated flags
    ev_user_halt = 1; ev_io_tmo = 1;
    @(posedge clk); @(negedge clk);
    clear_inputs();
    check("R6 accumulate before reset", 16'o000234, 1'b0, 1'b0);
    creset = 1;
    @(posedge clk); @(negedge clk);
    creset = 0;
    check("R10 creset clears", 16'o0, 1'b0, 1'b0);

    // R10: reset wins over simultaneous events
    greset = 1; ev_no_mem = 1; kpush_valid = 1; kpush_addr = 16'o376;
    @(posedge clk); @(negedge clk);
    greset = 0; clear_inputs();
    check("R10 greset beats events", 16'o0, 1'b0, 1'b0);
    creset = 1; kpush_valid = 1; kpush_addr = 16'o1001;
    @(posedge clk); @(negedge clk);
    creset = 0; clear_inputs();
    check("R10 creset beats push", 16'o0, 1'b0, 1'b0);

    // R7: after clearing the warning flag, a push traps again
    kpush_valid = 1; kpush_addr = 16'o350;
    @(posedge clk); @(negedge clk);
    clear_inputs();
    check("R7 trap after reset", 16'o000010, 1'b1, 1'b0);

    // R12 and R11: every event together with a write
    {ev_user_halt, ev_odd_addr, ev_no_mem, ev_io_tmo} = 4'b1111; bus_we = 1;
    @(posedge clk); @(negedge clk);
    clear_inputs();
    check("R12 R11 all events with write", 16'o000360, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule